// File: doc/BRIEF.md
# Self-Correcting Triplicated Configuration Register Bank

This block holds the configuration of a sixteen-channel front-end that sits in a radiation field. For each channel it stores an 8-bit discriminator threshold code, a 5-bit delay code, a 3-bit output-width code and a mask bit. Every stored bit exists in three copies. Logic downstream, and the read port, see only the 2-of-3 majority. Single-event upsets are repaired without any help from the host: in every cycle, each copy that disagrees with the vote is rewritten with the voted value. When a repair happens, the block raises a one-cycle flag and bumps a saturating 8-bit repair counter.

Access is through a plain strobe port that is meant to sit behind a serial control slave. There is one shared address, a write strobe with data, and a read strobe whose result comes back one cycle later. A separate upset port flips a single bit of one chosen copy. It models a particle hit so that the repair path can be exercised at the pins.

Top module: `tmr_cfg_bank`

## Requirements
- R1: After reset all three copies hold defaults: threshold registers 0x80, timing registers 0xE0 (width 7, delay 0), mask registers 0x00, and the repair counter is 0.
- R2: Address map: 0x00–0x0F threshold of channel n at address n; 0x10–0x1F timing of channel n at 0x10+n with delay in bits [4:0] and width in bits [7:5]; 0x20 holds mask bits of channels 0–7 and 0x21 of channels 8–15 (bit b = channel 8·k+b). A write on a mapped address loads all three copies at the next edge.
- R3: The outputs `thr_codes`, `dly_codes`, `wid_codes` and `ch_mask` present the voted contents, channel n at slice n of each bus.
- R4: A single upset in any one copy never changes any voted output or read result.
- R5: A copy that disagrees with the vote is rewritten at the next edge; `err_pulse` is high for exactly the one cycle after that edge, and a later upset in another copy of the same bit is again masked.
- R6: `err_cnt` increases by one for each cycle in which a repair takes place and holds at 255.
- R7: A read returns the voted value with `rd_valid` high in the cycle after the `rd_stb` cycle; an address from 0x22 upward reads as zero.
- R8: A write to an address from 0x22 upward changes no state.
- R9: A write and an upset on the same register in the same cycle leave all three copies equal to the written data, and no repair follows.
- R10: An upset with copy index 3 or with an unmapped address has no effect and causes no repair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address for reads and writes |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |
| upset_stb | input | 1 | Flip one stored bit (upset model) |
| upset_addr | input | 6 | Register hit by the upset |
| upset_copy | input | 2 | Copy hit (0–2; 3 ignored) |
| upset_bit | input | 3 | Bit position hit |
| thr_codes | output | 128 | Voted threshold codes, 8 bits per channel |
| dly_codes | output | 80 | Voted delay codes, 5 bits per channel |
| wid_codes | output | 48 | Voted width codes, 3 bits per channel |
| ch_mask | output | 16 | Voted channel mask bits |
| err_pulse | output | 1 | One-cycle repair indication |
| err_cnt | output | 8 | Saturating repair count |

## Verification
The bench aims upsets at registers and then aims a second upset at a different copy of the same bit. If the design only voted and never repaired, the second hit would corrupt the output. It also repeats repairs until the counter would pass 255, which catches a counter that wraps to zero. A write that collides with an upset on the same register checks that the write takes priority: a design that applied the flip afterwards would raise a spurious repair pulse. Reads and writes beyond the last register, and upsets aimed at copy 3, must leave every output and the repair count untouched.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;
  localparam int NCH      = 16;
  localparam int DW       = 8;
  localparam int DLY_W    = 5;
  localparam int WID_W    = 3;
  localparam int AW       = 6;
  localparam int BW       = $clog2(DW);
  localparam int CNT_W    = 8;
  localparam int NMSK     = (NCH + DW - 1) / DW;
  localparam int THR_BASE = 0;
  localparam int TIM_BASE = THR_BASE + NCH;
  localparam int MSK_BASE = TIM_BASE + NCH;
  localparam int NREG     = MSK_BASE + NMSK;

  typedef logic [DW-1:0] byte_t;

  localparam byte_t THR_RST = byte_t'(1 << (DW - 1));
  localparam byte_t TIM_RST = byte_t'(((1 << WID_W) - 1) << DLY_W);
  localparam byte_t MSK_RST = '0;

  function automatic byte_t maj3(input byte_t a, input byte_t b, input byte_t c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic byte_t reg_reset(input int idx);
    if (idx < TIM_BASE) return THR_RST;
    if (idx < MSK_BASE) return TIM_RST;
    return MSK_RST;
  endfunction

  function automatic logic is_mapped(input logic [AW-1:0] a);
    return int'(a) < NREG;
  endfunction
endpackage

// File: rtl/tmr_reg_cell.sv
module tmr_reg_cell
  import tmr_cfg_pkg::*;
#(
  parameter byte_t RST = '0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  byte_t       wr_val,
  input  logic        inj_en,
  input  logic [1:0]  inj_copy,
  input  byte_t       inj_mask,
  output byte_t       q,
  output logic        fix
);
  byte_t cp [3];
  logic  mism;

  assign q    = maj3(cp[0], cp[1], cp[2]);
  assign mism = (cp[0] != cp[1]) || (cp[1] != cp[2]);
  assign fix  = mism && !wr_en;

  for (genvar c = 0; c < 3; c++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst)
        cp[c] <= RST;
      else if (wr_en)
        cp[c] <= wr_val;
      else if (inj_en && inj_copy == 2'(c))
        cp[c] <= q ^ inj_mask;
      else
        cp[c] <= q;
    end
  end
endmodule

// File: rtl/tmr_repair_count.sv
module tmr_repair_count
  import tmr_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             any_fix,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_cnt   <= '0;
    end else begin
      err_pulse <= any_fix;
      if (any_fix && err_cnt != CMAX) err_cnt <= err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank
  import tmr_cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   wr_stb,
  input  logic [DW-1:0]          wr_data,
  input  logic                   rd_stb,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_valid,
  input  logic                   upset_stb,
  input  logic [AW-1:0]          upset_addr,
  input  logic [1:0]             upset_copy,
  input  logic [BW-1:0]          upset_bit,
  output logic [NCH*DW-1:0]      thr_codes,
  output logic [NCH*DLY_W-1:0]   dly_codes,
  output logic [NCH*WID_W-1:0]   wid_codes,
  output logic [NCH-1:0]         ch_mask,
  output logic                   err_pulse,
  output logic [CNT_W-1:0]       err_cnt
);
  byte_t            voted [NREG];
  logic [NREG-1:0]  fix_vec;
  logic             any_fix;
  byte_t            inj_mask;

  assign inj_mask = byte_t'(1) << upset_bit;
  assign any_fix  = |fix_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    tmr_reg_cell #(.RST(reg_reset(i))) u_cell (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_stb && bus_addr == AW'(i)),
      .wr_val   (wr_data),
      .inj_en   (upset_stb && upset_addr == AW'(i)),
      .inj_copy (upset_copy),
      .inj_mask (inj_mask),
      .q        (voted[i]),
      .fix      (fix_vec[i])
    );
  end

  for (genvar n = 0; n < NCH; n++) begin : g_out
    assign thr_codes[n*DW +: DW]       = voted[THR_BASE+n];
    assign dly_codes[n*DLY_W +: DLY_W] = voted[TIM_BASE+n][DLY_W-1:0];
    assign wid_codes[n*WID_W +: WID_W] = voted[TIM_BASE+n][DLY_W +: WID_W];
    assign ch_mask[n]                  = voted[MSK_BASE + n/DW][n%DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= is_mapped(bus_addr) ? voted[bus_addr] : '0;
    end
  end

  tmr_repair_count u_cnt (
    .clk       (clk),
    .rst       (rst),
    .any_fix   (any_fix),
    .err_pulse (err_pulse),
    .err_cnt   (err_cnt)
  );
endmodule

// File: rtl/tmr_cfg_bank_chk.sv
module tmr_cfg_bank_chk
  import tmr_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic             rd_stb,
  input logic [DW-1:0]    rd_data,
  input logic             rd_valid,
  input logic             upset_stb,
  input logic             any_fix,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_fix_flags_R5: assert property (@(posedge clk) disable iff (rst)
    any_fix |=> err_pulse);

  assert_repair_done_R5: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && !$past(upset_stb)) |-> !any_fix);

  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (err_cnt == CMAX) |=> (err_cnt == CMAX));

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1 && err_pulse));

  assert_rd_valid_R7: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !is_mapped(bus_addr)) |=> (rd_data == '0));
endmodule

bind tmr_cfg_bank tmr_cfg_bank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .rd_stb    (rd_stb),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .upset_stb (upset_stb),
  .any_fix   (any_fix),
  .err_pulse (err_pulse),
  .err_cnt   (err_cnt)
);

// File: tb/tb_tmr_cfg_bank.sv
module tb_tmr_cfg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        upset_stb = 1'b0;
  logic [5:0]  upset_addr = '0;
  logic [1:0]  upset_copy = '0;
  logic [2:0]  upset_bit = '0;
  logic [127:0] thr_codes;
  logic [79:0]  dly_codes;
  logic [47:0]  wid_codes;
  logic [15:0]  ch_mask;
  logic         err_pulse;
  logic [7:0]   err_cnt;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [NR];
  int exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cfg_bank dut (.*);

  function automatic logic [7:0] dflt(input int i);
    if (i < 16) return 8'h80;
    if (i < 32) return 8'hE0;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_buses(input string req);
    logic [127:0] t; logic [79:0] d; logic [47:0] w; logic [15:0] m;
    for (int n = 0; n < 16; n++) begin
      t[n*8 +: 8] = mdl[n];
      d[n*5 +: 5] = mdl[16+n][4:0];
      w[n*3 +: 3] = mdl[16+n][7:5];
      m[n]        = mdl[32 + n/8][n%8];
    end
    chk(req, "thr_codes", thr_codes, t);
    chk(req, "dly_codes", 128'(dly_codes), 128'(d));
    chk(req, "wid_codes", 128'(wid_codes), 128'(w));
    chk(req, "ch_mask", 128'(ch_mask), 128'(m));
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (int'(a) < NR) mdl[a] = d;
  endtask

  task automatic do_read(input logic [5:0] a, input string req);
    bus_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(req, "rd_valid", 128'(rd_valid), 128'(1));
    chk(req, "rd_data", 128'(rd_data), (int'(a) < NR) ? 128'(mdl[a]) : 128'(0));
  endtask

  task automatic do_upset(input logic [5:0] a, input logic [1:0] c, input logic [2:0] b, input bit quick);
    bit hit;
    hit = (int'(a) < NR) && (c != 2'd3);
    upset_addr = a; upset_copy = c; upset_bit = b; upset_stb = 1'b1;
    @(negedge clk);
    upset_stb = 1'b0;
    if (!quick) begin
      chk("R4", "outputs after upset", 128'(err_pulse), 128'(0));
      chk_buses("R4");
    end
    @(negedge clk);
    if (hit && exp_cnt < 255) exp_cnt++;
    chk(hit ? "R5" : "R10", "err_pulse", 128'(err_pulse), 128'(hit));
    chk("R6", "err_cnt", 128'(err_cnt), 128'(exp_cnt));
    if (!quick) begin
      @(negedge clk);
      chk("R5", "pulse width", 128'(err_pulse), 128'(0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd4711);
    for (int i = 0; i < NR; i++) mdl[i] = dflt(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset defaults
    chk_buses("R1");
    chk("R1", "err_cnt", 128'(err_cnt), 128'(0));
    do_read(6'h00, "R1");
    do_read(6'h10, "R1");
    do_read(6'h21, "R1");
    // R2 / R3 directed writes
    do_write(6'h05, 8'h3C);
    do_write(6'h13, 8'b101_10110);
    do_write(6'h21, 8'h81);
    chk_buses("R3");
    do_read(6'h05, "R2");
    do_read(6'h13, "R2");
    do_read(6'h21, "R2");
    // R7 / R8 unmapped
    do_write(6'h22, 8'hFF);
    do_write(6'h3F, 8'hA5);
    chk_buses("R8");
    do_read(6'h22, "R7");
    do_read(6'h3F, "R7");
    chk("R8", "err_cnt", 128'(err_cnt), 128'(0));
    // R5 repair then second copy of same bit
    do_upset(6'h05, 2'd0, 3'd2, 1'b0);
    do_upset(6'h05, 2'd1, 3'd2, 1'b0);
    do_read(6'h05, "R5");
    do_upset(6'h20, 2'd2, 3'd7, 1'b0);
    do_upset(6'h20, 2'd0, 3'd7, 1'b0);
    chk_buses("R5");
    // R10 ignored upsets
    do_upset(6'h07, 2'd3, 3'd1, 1'b0);
    do_upset(6'h2A, 2'd0, 3'd1, 1'b0);
    chk_buses("R10");
    // R9 write colliding with upset
    upset_addr = 6'h09; upset_copy = 2'd1; upset_bit = 3'd0; upset_stb = 1'b1;
    do_write(6'h09, 8'h11);
    upset_stb = 1'b0;
    @(negedge clk);
    chk("R9", "err_pulse", 128'(err_pulse), 128'(0));
    chk("R9", "err_cnt", 128'(err_cnt), 128'(exp_cnt));
    do_upset(6'h09, 2'd0, 3'd0, 1'b0);
    do_read(6'h09, "R9");
    // random mix
    for (int k = 0; k < 400; k++) begin
      int unsigned op;
      op = $urandom % 3;
      if (op == 0) do_write(6'($urandom % 36), 8'($urandom));
      else if (op == 1) do_read(6'($urandom % 36), "R7");
      else do_upset(6'($urandom % NR), 2'($urandom % 3), 3'($urandom), 1'b0);
    end
    chk_buses("R3");
    // R6 saturation
    for (int k = 0; k < 270; k++)
      do_upset(6'($urandom % NR), 2'($urandom % 3), 3'($urandom), 1'b1);
    chk("R6", "saturated", 128'(err_cnt), 128'(255));
    do_upset(6'h01, 2'd2, 3'd4, 1'b0);
    chk("R6", "held", 128'(err_cnt), 128'(255));
    chk_buses("R4");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule